// File: doc/BRIEF.md
# Codec command ring fetcher

This block drains a ring of 32-bit codec command words held in system memory and hands each one, split into its fields, to the codec link. Software sets a ring base address, turns the ring on and advances a write pointer; the block then reads entries one at a time through a simple memory read port, moves its own read pointer forward, and presents each command with a one-cycle valid strobe. A separate immediate-command register lets software push a single command outside the ring. That command always wins over the next ring entry.

Fetching stops for any of three reasons: the run bit is off, the ring is empty, or the response writer reports that its programmed response count has been reached. Once stopped, the block stays idle until software writes the write pointer, the control register or the immediate register. A command is discarded if it asks for indirect node addressing or names a codec address whose presence bit is clear.

The controller is a four-state machine. `S_IDLE` waits for a write that re-triggers fetching. `S_CHECK` arbitrates:
- an immediate command moves to `S_ISSUE`;
- a stop condition returns to `S_IDLE`;
- otherwise it advances the read pointer and moves to `S_WAIT`.

`S_WAIT` holds the memory request until it is acknowledged, then moves to `S_ISSUE`. `S_ISSUE` decodes the latched command, strobes it out if it is acceptable, and returns to `S_CHECK`.

Top module: `cmd_ring_fetcher`

## Requirements
- R1: A dispatched command carries codec address = word bits 31:28, node ID = bits 26:20, payload = bits 19:0, and commands leave in fetch order.
- R2: A word with bit 27 set is never dispatched, whether it comes from the ring or from the immediate register.
- R3: A word whose codec address has its `codec_present` bit clear is never dispatched.
- R4: Writing `reg_sel`=3 loads the immediate word and sets `imm_busy`. While busy, the immediate word is taken before any further ring entry, including when the run bit is clear. `imm_busy` clears once the word is taken.
- R5: While the run bit (`reg_sel`=2, data bit 0) is clear, no memory read is issued.
- R6: No memory read is issued while `rd_ptr` equals the write pointer (`reg_sel`=1, data bits 7:0).
- R7: No memory read is issued while `resp_limit_hit` is high.
- R8: Each fetch first increments `rd_ptr` modulo 256. It then reads from base (`reg_sel`=0, low two bits forced to zero) plus four times the new `rd_ptr`.
- R9: After fetching has stopped, removing the stop cause alone starts nothing. Only a write with `reg_sel` 1, 2 or 3 starts a new attempt.
- R10: At most one read is outstanding: `mem_req` stays high with a stable `mem_addr` until `mem_ack`, and no new request starts until the command from the previous one has been handled.
- R11: A synchronous reset clears `rd_ptr`, the write pointer, the run bit and `imm_busy`, and leaves `mem_req` and `cmd_valid` low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| reg_we | input | 1 | Register write strobe |
| reg_sel | input | 2 | Register select: 0 base, 1 write pointer, 2 control, 3 immediate |
| reg_wdata | input | 32 | Register write data |
| mem_req | output | 1 | Memory read request, held until acknowledged |
| mem_addr | output | AW | Byte address of the ring entry |
| mem_ack | input | 1 | Read data valid |
| mem_rdata | input | 32 | Read data |
| resp_limit_hit | input | 1 | Response writer has reached its programmed count |
| codec_present | input | 16 | One bit per codec address |
| cmd_valid | output | 1 | Command strobe |
| cmd_cad | output | 4 | Codec address |
| cmd_nid | output | 7 | Node ID |
| cmd_payload | output | 20 | Verb and data payload |
| rd_ptr | output | 8 | Ring read pointer |
| imm_busy | output | 1 | Immediate command pending |

## Verification
The hardest situation to reach from the ports is an immediate command that arrives while a ring read is already in flight. In that case the in-flight entry must still be issued first, and the immediate word must then pre-empt the remaining ring entries. The bench reaches this by giving its memory model a 20-cycle latency, writing the write pointer, and writing the immediate register a few cycles later while the first read is still waiting. A full sweep of all 256 ring slots, including the wrap past zero, covers the address arithmetic. Dropped and accepted words are mixed arithmetically across that sweep.

// File: rtl/cfr_pkg.sv
package cfr_pkg;
    typedef enum logic [1:0] {
        S_IDLE  = 2'd0,
        S_CHECK = 2'd1,
        S_WAIT  = 2'd2,
        S_ISSUE = 2'd3
    } cfr_state_e;

    typedef enum logic [1:0] {
        SEL_BASE = 2'd0,
        SEL_WPTR = 2'd1,
        SEL_CTRL = 2'd2,
        SEL_IMM  = 2'd3
    } cfr_sel_e;

    localparam int WORD_W = 32;
    localparam int CAD_W  = 4;
    localparam int NID_W  = 7;
    localparam int PL_W   = 20;
    localparam int NCODEC = 1 << CAD_W;
endpackage

// File: rtl/cfr_verb_decode.sv
module cfr_verb_decode
    import cfr_pkg::*;
(
    input  logic [WORD_W-1:0] word,
    output logic [CAD_W-1:0]  cad,
    output logic              indirect,
    output logic [NID_W-1:0]  nid,
    output logic [PL_W-1:0]   payload
);
    always_comb begin
        cad      = word[WORD_W-1 -: CAD_W];
        indirect = word[PL_W+NID_W];
        nid      = word[PL_W +: NID_W];
        payload  = word[PL_W-1:0];
    end
endmodule

// File: rtl/cfr_regs.sv
module cfr_regs
    import cfr_pkg::*;
#(
    parameter int AW    = 32,
    parameter int PTR_W = 8
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              we,
    input  logic [1:0]        sel,
    input  logic [WORD_W-1:0] wdata,
    input  logic              imm_take,
    input  logic              kick_clr,
    output logic [AW-1:0]     base_o,
    output logic [PTR_W-1:0]  wptr_o,
    output logic              run_o,
    output logic [WORD_W-1:0] imm_word_o,
    output logic              busy_o,
    output logic              kick_o
);
    always_ff @(posedge clk) begin
        if (rst) begin
            base_o     <= '0;
            wptr_o     <= '0;
            run_o      <= 1'b0;
            imm_word_o <= '0;
            busy_o     <= 1'b0;
            kick_o     <= 1'b0;
        end else begin
            if (imm_take) busy_o <= 1'b0;
            if (kick_clr) kick_o <= 1'b0;
            if (we) begin
                unique case (cfr_sel_e'(sel))
                    SEL_BASE: base_o <= AW'(wdata) & ~AW'(3);
                    SEL_WPTR: begin
                        wptr_o <= wdata[PTR_W-1:0];
                        kick_o <= 1'b1;
                    end
                    SEL_CTRL: begin
                        run_o  <= wdata[0];
                        kick_o <= 1'b1;
                    end
                    SEL_IMM: begin
                        imm_word_o <= wdata;
                        busy_o     <= 1'b1;
                        kick_o     <= 1'b1;
                    end
                    default: ;
                endcase
            end
        end
    end
endmodule

// File: rtl/cmd_ring_fetcher.sv
module cmd_ring_fetcher
    import cfr_pkg::*;
#(
    parameter int AW    = 32,
    parameter int PTR_W = 8
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              reg_we,
    input  logic [1:0]        reg_sel,
    input  logic [WORD_W-1:0] reg_wdata,
    output logic              mem_req,
    output logic [AW-1:0]     mem_addr,
    input  logic              mem_ack,
    input  logic [WORD_W-1:0] mem_rdata,
    input  logic              resp_limit_hit,
    input  logic [NCODEC-1:0] codec_present,
    output logic              cmd_valid,
    output logic [CAD_W-1:0]  cmd_cad,
    output logic [NID_W-1:0]  cmd_nid,
    output logic [PL_W-1:0]   cmd_payload,
    output logic [PTR_W-1:0]  rd_ptr,
    output logic              imm_busy
);
    localparam int ENTRY_SHIFT = 2;

    cfr_state_e        state_q;
    logic [WORD_W-1:0] verb_q;
    logic [PTR_W-1:0]  rd_ptr_q;
    logic [AW-1:0]     base_w;
    logic [PTR_W-1:0]  wptr_w;
    logic              run_w;
    logic [WORD_W-1:0] imm_word_w;
    logic              kick_w;
    logic              imm_take;
    logic              kick_clr;
    logic              stop_w;
    logic              ind_w;

    cfr_regs #(.AW(AW), .PTR_W(PTR_W)) u_regs (
        .clk        (clk),
        .rst        (rst),
        .we         (reg_we),
        .sel        (reg_sel),
        .wdata      (reg_wdata),
        .imm_take   (imm_take),
        .kick_clr   (kick_clr),
        .base_o     (base_w),
        .wptr_o     (wptr_w),
        .run_o      (run_w),
        .imm_word_o (imm_word_w),
        .busy_o     (imm_busy),
        .kick_o     (kick_w)
    );

    cfr_verb_decode u_dec (
        .word     (verb_q),
        .cad      (cmd_cad),
        .indirect (ind_w),
        .nid      (cmd_nid),
        .payload  (cmd_payload)
    );

    assign stop_w = !run_w || (rd_ptr_q == wptr_w) || resp_limit_hit;

    always_ff @(posedge clk) begin
        if (rst) begin
            state_q  <= S_IDLE;
            verb_q   <= '0;
            rd_ptr_q <= '0;
        end else begin
            unique case (state_q)
                S_IDLE:  if (kick_w) state_q <= S_CHECK;
                S_CHECK: begin
                    if (imm_busy) begin
                        verb_q  <= imm_word_w;
                        state_q <= S_ISSUE;
                    end else if (stop_w) begin
                        state_q <= S_IDLE;
                    end else begin
                        rd_ptr_q <= rd_ptr_q + 1'b1;
                        state_q  <= S_WAIT;
                    end
                end
                S_WAIT: begin
                    if (mem_ack) begin
                        verb_q  <= mem_rdata;
                        state_q <= S_ISSUE;
                    end
                end
                S_ISSUE: state_q <= S_CHECK;
                default: state_q <= S_IDLE;
            endcase
        end
    end

    always_comb begin
        imm_take  = (state_q == S_CHECK) && imm_busy;
        kick_clr  = (state_q == S_CHECK) && !imm_busy && stop_w;
        mem_req   = (state_q == S_WAIT);
        mem_addr  = base_w + AW'({rd_ptr_q, {ENTRY_SHIFT{1'b0}}});
        cmd_valid = (state_q == S_ISSUE) && !ind_w && codec_present[cmd_cad];
        rd_ptr    = rd_ptr_q;
    end
endmodule

// File: rtl/cfr_chk.sv
module cfr_chk #(
    parameter int AW    = 32,
    parameter int PTR_W = 8
) (
    input logic             clk,
    input logic             rst,
    input logic             mem_req,
    input logic             mem_ack,
    input logic [AW-1:0]    mem_addr,
    input logic [PTR_W-1:0] rd_ptr,
    input logic [PTR_W-1:0] wptr,
    input logic             run,
    input logic             busy,
    input logic             limit,
    input logic             cmd_valid,
    input logic [3:0]       cmd_cad,
    input logic [15:0]      present
);
    // R10
    req_hold_chk: assert property (@(posedge clk) disable iff (rst)
        (mem_req && !mem_ack) |=> (mem_req && $stable(mem_addr)));
    // R3
    present_only_chk: assert property (@(posedge clk) disable iff (rst)
        cmd_valid |-> present[cmd_cad]);
    // R5
    run_gate_chk: assert property (@(posedge clk) disable iff (rst)
        $rose(mem_req) |-> $past(run));
    // R6
    not_empty_chk: assert property (@(posedge clk) disable iff (rst)
        $rose(mem_req) |-> ($past(rd_ptr) != $past(wptr)));
    // R7
    limit_gate_chk: assert property (@(posedge clk) disable iff (rst)
        $rose(mem_req) |-> !$past(limit));
    // R8
    ptr_step_chk: assert property (@(posedge clk) disable iff (rst)
        $rose(mem_req) |-> (rd_ptr == $past(rd_ptr) + 1'b1));
    // R4
    imm_first_chk: assert property (@(posedge clk) disable iff (rst)
        $rose(mem_req) |-> !$past(busy));
    // R11
    reset_state_chk: assert property (@(posedge clk)
        rst |=> (rd_ptr == '0 && !busy && !run && wptr == '0));
endmodule

bind cmd_ring_fetcher cfr_chk #(.AW(AW), .PTR_W(PTR_W)) u_chk (
    .clk       (clk),
    .rst       (rst),
    .mem_req   (mem_req),
    .mem_ack   (mem_ack),
    .mem_addr  (mem_addr),
    .rd_ptr    (rd_ptr),
    .wptr      (wptr_w),
    .run       (run_w),
    .busy      (imm_busy),
    .limit     (resp_limit_hit),
    .cmd_valid (cmd_valid),
    .cmd_cad   (cmd_cad),
    .present   (codec_present)
);

// File: tb/cmd_ring_fetcher_tb.sv
`timescale 1ns/1ps
module cmd_ring_fetcher_tb;
    localparam logic [31:0] BASE = 32'h0000_1000;
    localparam logic [15:0] PRES = 16'h7FFE;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        reg_we = 1'b0;
    logic [1:0]  reg_sel = '0;
    logic [31:0] reg_wdata = '0;
    logic        mem_req;
    logic [31:0] mem_addr;
    logic        mem_ack = 1'b0;
    logic [31:0] mem_rdata = '0;
    logic        limit = 1'b0;
    logic        cmd_valid;
    logic [3:0]  cmd_cad;
    logic [6:0]  cmd_nid;
    logic [19:0] cmd_payload;
    logic [7:0]  rd_ptr;
    logic        imm_busy;

    int checks = 0, fails = 0;
    int exp_n = 0, obs_n = 0;
    int exp_reads = 0, reads_n = 0;
    int exp_rp = 0;
    int lat = 0, lat_cnt = 0;
    logic req_prev = 1'b0;
    logic done = 1'b0;
    logic [31:0] exp_q [0:1023];

    always #2.5 clk = ~clk;

    cmd_ring_fetcher u_dut (
        .clk(clk), .rst(rst), .reg_we(reg_we), .reg_sel(reg_sel), .reg_wdata(reg_wdata),
        .mem_req(mem_req), .mem_addr(mem_addr), .mem_ack(mem_ack), .mem_rdata(mem_rdata),
        .resp_limit_hit(limit), .codec_present(PRES),
        .cmd_valid(cmd_valid), .cmd_cad(cmd_cad), .cmd_nid(cmd_nid),
        .cmd_payload(cmd_payload), .rd_ptr(rd_ptr), .imm_busy(imm_busy)
    );

    function automatic logic [31:0] vgen(int i);
        logic [3:0]  c = 4'((i * 5) % 16);
        logic        d = ((i % 7) == 3);
        logic [6:0]  n = 7'((i * 3) % 128);
        logic [19:0] p = 20'((i * 4099 + 17) % 1048576);
        return {c, d, n, p};
    endfunction

    task automatic check(input bit ok, input string req, input int act, input int exp);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    // R2 R3: expected list drops indirect words and absent codecs
    task automatic push(input logic [31:0] v);
        if (!v[27] && PRES[v[31:28]]) begin
            exp_q[exp_n] = v;
            exp_n++;
        end
    endtask

    task automatic push_ring(input int from, input int to);
        int p = from;
        while (p != to) begin
            p = (p + 1) % 256;
            push(vgen(p));
            exp_reads++;
        end
    endtask

    task automatic wr(input logic [1:0] s, input logic [31:0] d);
        @(negedge clk);
        reg_we = 1'b1; reg_sel = s; reg_wdata = d;
        @(negedge clk);
        reg_we = 1'b0;
    endtask

    task automatic settle(input int n);
        repeat (n) @(negedge clk);
    endtask

    // memory model and R8 address check
    always @(negedge clk) begin
        if (mem_req && !req_prev) begin
            reads_n++;
            exp_rp = (exp_rp + 1) % 256;
            check(mem_addr == BASE + 32'(exp_rp * 4), "R8 addr", int'(mem_addr), int'(BASE) + exp_rp * 4);
        end
        req_prev = mem_req;
        if (mem_req) begin
            if (lat_cnt >= lat) begin
                mem_ack   = 1'b1;
                mem_rdata = vgen(int'((mem_addr - BASE) >> 2));
                lat_cnt   = 0;
            end else begin
                mem_ack = 1'b0;
                lat_cnt++;
            end
        end else begin
            mem_ack = 1'b0;
            lat_cnt = 0;
        end
    end

    // R1 command monitor
    always @(negedge clk) begin
        if (!rst && cmd_valid) begin
            if (obs_n < exp_n)
                check({cmd_cad, cmd_nid, cmd_payload} == {exp_q[obs_n][31:28], exp_q[obs_n][26:0]},
                      "R1 fields", int'({cmd_cad, cmd_nid, cmd_payload}),
                      int'({exp_q[obs_n][31:28], exp_q[obs_n][26:0]}));
            else
                check(1'b0, "R1 extra cmd", obs_n + 1, exp_n);
            obs_n++;
        end
    end

    initial begin
        repeat (150000) @(posedge clk);
        if (!done) begin
            checks++; fails++;
            $display("FAIL watchdog actual=running expected=done");
            $display("%0d/%0d checks passed", checks - fails, checks);
            $finish;
        end
    end

    initial begin
        settle(4);
        // R11 reset state
        check(rd_ptr == 0 && !imm_busy && !mem_req && !cmd_valid, "R11 reset",
              int'({rd_ptr, imm_busy, mem_req, cmd_valid}), 0);
        rst = 1'b0;
        settle(2);

        wr(2'd0, BASE | 32'h3);
        wr(2'd2, 32'h1);
        push_ring(0, 5);
        wr(2'd1, 32'd5);
        settle(100);
        check(rd_ptr == 8'd5, "R8 ptr", rd_ptr, 5);
        check(obs_n == exp_n, "R1 count", obs_n, exp_n);
        check(reads_n == exp_reads, "R6 reads", reads_n, exp_reads);

        // wrap through all remaining slots
        push_ring(5, 0);
        wr(2'd1, 32'd0);
        settle(1500);
        check(rd_ptr == 8'd0, "R8 wrap", rd_ptr, 0);
        check(obs_n == exp_n, "R2 R3 count", obs_n, exp_n);
        check(reads_n == exp_reads, "R6 reads", reads_n, exp_reads);

        // R5 run clear
        wr(2'd2, 32'h0);
        wr(2'd1, 32'd10);
        settle(50);
        check(rd_ptr == 8'd0 && reads_n == exp_reads, "R5 stopped", rd_ptr, 0);

        // R7 limit, R9 no restart without a write
        limit = 1'b1;
        wr(2'd2, 32'h1);
        settle(50);
        check(rd_ptr == 8'd0 && reads_n == exp_reads, "R7 paused", rd_ptr, 0);
        limit = 1'b0;
        settle(50);
        check(rd_ptr == 8'd0 && reads_n == exp_reads, "R9 no kick", rd_ptr, 0);
        push_ring(0, 10);
        wr(2'd1, 32'd10);
        settle(200);
        check(rd_ptr == 8'd10, "R9 kicked", rd_ptr, 10);
        check(obs_n == exp_n, "R9 count", obs_n, exp_n);

        // R4 immediate with run clear, R2 R3 on immediate words
        wr(2'd2, 32'h0);
        push(32'h3123_4567);
        wr(2'd3, 32'h3123_4567);
        settle(10);
        check(!imm_busy && obs_n == exp_n, "R4 imm", obs_n, exp_n);
        wr(2'd3, 32'h3823_4567);
        settle(10);
        check(!imm_busy && obs_n == exp_n, "R2 imm", obs_n, exp_n);
        wr(2'd3, 32'hF023_4567);
        settle(10);
        check(!imm_busy && obs_n == exp_n, "R3 imm", obs_n, exp_n);

        // R4 R10 priority while a read is in flight
        lat = 20;
        wr(2'd2, 32'h1);
        push(vgen(11));
        push(32'h5055_AAAA);
        push(vgen(12));
        push(vgen(13));
        exp_reads += 3;
        wr(2'd1, 32'd13);
        settle(5);
        check(mem_req, "R10 in flight", mem_req, 1);
        wr(2'd3, 32'h5055_AAAA);
        settle(200);
        check(obs_n == exp_n && rd_ptr == 8'd13, "R4 order", obs_n, exp_n);
        check(reads_n == exp_reads, "R10 reads", reads_n, exp_reads);

        done = 1'b1;
        $display("%0d/%0d checks passed", checks - fails, checks);
        $finish;
    end
endmodule